// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block is the loop-control slice of a program sequencer. It handles counted hardware loops, so the core can repeat a loop body with no branch instruction and no lost fetch slot. When the decoder recognises a loop-start instruction, it asserts a push strobe. With the strobe it supplies the iteration count and the address of the last instruction of the loop body. The block takes the address after the loop-start instruction as the body's first address and stores all three values on a small hardware stack.

On every fetch the block compares the fetch address with the end address of the innermost active loop only. It produces the next fetch address combinationally in the same cycle. If iterations remain, it redirects the fetch to the body start and decrements the stored count. On the final pass it pops the loop, and the fetch continues at the following address. Loops nest up to the stack depth.

Top module: `loop_sequencer`

## Requirements
- R1: After a synchronous reset, `depth_o` is 0, `overflow_o` is 0, and a fetch at any address gives `next_pc_o` = `pc_i`+1 with `loop_back_o` low.
- R2: A cycle with `push_i` high and depth below STACK_DEPTH (default 6) stores start = `pc_i`+1, end = `push_end_i` and count = `push_cnt_i`, and increments `depth_o` by one.
- R3: A push while depth equals STACK_DEPTH is ignored: the depth and the stored entries are unchanged. `overflow_o` goes high and stays high until reset.
- R4: A fetch (`fetch_i` high, `push_i` low) at the innermost loop's end address with a remaining count above 1 drives `loop_back_o` high and `next_pc_o` to the loop start in that same cycle. It decrements the count and leaves the depth unchanged.
- R5: A fetch at the innermost loop's end address with a remaining count of 1 pops that loop (depth minus one) and gives `next_pc_o` = `pc_i`+1 with `loop_back_o` low.
- R6: A pushed count of 0 behaves as a count of 1: the body runs once with no loop-back.
- R7: Only the innermost loop's end address is compared. In a nested program, an outer loop of count 2 around an inner loop of count 3 executes the inner body 6 times and loops back 5 times in total.
- R8: When nested loops share one end address, a single fetch of that address acts only on the innermost loop. When the inner loop expires, execution falls through with the outer loop still on the stack.
- R9: In a cycle with `push_i` high, no end-address comparison is made: `loop_back_o` is low and `next_pc_o` = `pc_i`+1, even when `pc_i` equals the current end address.
- R10: A cycle with `fetch_i` low and `push_i` low changes no state and keeps `loop_back_o` low.
- R11: A fetch at an address other than the innermost end address gives `next_pc_o` = `pc_i`+1 and leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_i | input | 1 | A fetch at `pc_i` takes place this cycle |
| pc_i | input | ADDR_W | Current fetch address |
| push_i | input | 1 | Loop-start instruction decoded at `pc_i` |
| push_cnt_i | input | CNT_W | Iteration count of the new loop |
| push_end_i | input | ADDR_W | Address of the new loop's last instruction |
| next_pc_o | output | ADDR_W | Next fetch address, valid in the same cycle |
| loop_back_o | output | 1 | Fetch redirected to a loop start this cycle |
| depth_o | output | $clog2(STACK_DEPTH+1) | Number of active loops |
| overflow_o | output | 1 | Sticky flag: a push was dropped on a full stack |

## Verification
The sequencer is driven as a small program. The bench follows `next_pc_o` from fetch to fetch and counts loop-backs and fetches until control leaves the program. The program shapes are:
- a plain loop of count 3, which separates a correct redirect from a missing or late one;
- counts of 0 and 1, which show whether a zero count wraps into a long loop;
- a two-level nest with distinct end addresses, which shows whether only the innermost end is compared;
- a nest that shares one end address, which shows whether one fetch unwinds one loop or several.

Separate directed cases try a push exactly at a live end address, an idle cycle at an end address, and seven pushes into a six-entry stack. In the overflow case, the bench probes the dropped entry's end address and the surviving entry's end address to show which entry remained on top.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_DEC  = 2'd2,
        STK_POP  = 2'd3
    } stk_op_e;

endpackage

// File: rtl/loop_slot.sv
module loop_slot #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              wr_i,
    input  logic              dec_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] end_o,
    output logic [CNT_W-1:0]  cnt_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] stop;
        logic [CNT_W-1:0]  cnt;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_i) begin
            slot_d.start = start_i;
            slot_d.stop  = end_i;
            slot_d.cnt   = cnt_i;
        end else if (dec_i) begin
            slot_d.cnt = slot_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        slot_q <= slot_d;
    end

    assign start_o = slot_q.start;
    assign end_o   = slot_q.stop;
    assign cnt_o   = slot_q.cnt;

endmodule

// File: rtl/loop_stack.sv
module loop_stack
    import loop_seq_pkg::*;
#(
    parameter int STACK_DEPTH = 6,
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 16,
    localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op_i,
    input  logic [ADDR_W-1:0] new_start_i,
    input  logic [ADDR_W-1:0] new_end_i,
    input  logic [CNT_W-1:0]  new_cnt_i,
    output logic [ADDR_W-1:0] top_start_o,
    output logic [ADDR_W-1:0] top_end_o,
    output logic [CNT_W-1:0]  top_cnt_o,
    output logic              empty_o,
    output logic [SP_W-1:0]   depth_o,
    output logic              overflow_o
);

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic            ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              full;
    logic [CNT_W-1:0]  cnt_fixed;
    logic [ADDR_W-1:0] s_start [STACK_DEPTH];
    logic [ADDR_W-1:0] s_end   [STACK_DEPTH];
    logic [CNT_W-1:0]  s_cnt   [STACK_DEPTH];
    logic [STACK_DEPTH-1:0] wr_en, dec_en;

    assign full      = (ctl_q.sp == SP_W'(STACK_DEPTH));
    assign cnt_fixed = (new_cnt_i == '0) ? CNT_W'(1) : new_cnt_i;

    always_comb begin
        ctl_d = ctl_q;
        unique case (op_i)
            STK_PUSH: begin
                if (full) ctl_d.ovf = 1'b1;
                else      ctl_d.sp  = ctl_q.sp + SP_W'(1);
            end
            STK_POP: begin
                if (ctl_q.sp != '0) ctl_d.sp = ctl_q.sp - SP_W'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < STACK_DEPTH; g++) begin : g_slot
        assign wr_en[g]  = (op_i == STK_PUSH) && (ctl_q.sp == SP_W'(g));
        assign dec_en[g] = (op_i == STK_DEC)  && (ctl_q.sp == SP_W'(g + 1));

        loop_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .wr_i    (wr_en[g]),
            .dec_i   (dec_en[g]),
            .start_i (new_start_i),
            .end_i   (new_end_i),
            .cnt_i   (cnt_fixed),
            .start_o (s_start[g]),
            .end_o   (s_end[g]),
            .cnt_o   (s_cnt[g])
        );
    end

    always_comb begin
        top_start_o = s_start[0];
        top_end_o   = s_end[0];
        top_cnt_o   = s_cnt[0];
        for (int i = 1; i < STACK_DEPTH; i++) begin
            if (ctl_q.sp == SP_W'(i + 1)) begin
                top_start_o = s_start[i];
                top_end_o   = s_end[i];
                top_cnt_o   = s_cnt[i];
            end
        end
    end

    assign empty_o    = (ctl_q.sp == '0);
    assign depth_o    = ctl_q.sp;
    assign overflow_o = ctl_q.ovf;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_q.sp <= SP_W'(STACK_DEPTH));

    assert_sticky_flag_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_q.ovf |=> ctl_q.ovf);

    assert_full_push_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_PUSH && full) |=> (ctl_q.ovf && $stable(ctl_q.sp)));

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_PUSH && !full) |=> (ctl_q.sp == $past(ctl_q.sp) + SP_W'(1)));

endmodule

// File: rtl/loop_match.sv
module loop_match
    import loop_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              fetch_i,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              empty_i,
    input  logic [ADDR_W-1:0] top_start_i,
    input  logic [ADDR_W-1:0] top_end_i,
    input  logic [CNT_W-1:0]  top_cnt_i,
    output stk_op_e           op_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              loop_back_o
);

    logic hit, last_pass;

    assign hit       = fetch_i && !push_i && !empty_i && (pc_i == top_end_i);
    assign last_pass = (top_cnt_i <= CNT_W'(1));

    always_comb begin
        op_o        = STK_IDLE;
        loop_back_o = 1'b0;
        next_pc_o   = pc_i + ADDR_W'(1);
        if (push_i) begin
            op_o = STK_PUSH;
        end else if (hit) begin
            if (last_pass) begin
                op_o = STK_POP;
            end else begin
                op_o        = STK_DEC;
                loop_back_o = 1'b1;
                next_pc_o   = top_start_i;
            end
        end
    end

    always_comb begin
        if (push_i) assert_push_no_compare_R9: assert (!loop_back_o);
    end

endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
    import loop_seq_pkg::*;
#(
    parameter int STACK_DEPTH = 6,
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 16,
    localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              push_i,
    input  logic [CNT_W-1:0]  push_cnt_i,
    input  logic [ADDR_W-1:0] push_end_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              loop_back_o,
    output logic [SP_W-1:0]   depth_o,
    output logic              overflow_o
);

    stk_op_e           op;
    logic [ADDR_W-1:0] top_start, top_end;
    logic [CNT_W-1:0]  top_cnt;
    logic              empty;

    loop_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
        .fetch_i     (fetch_i),
        .push_i      (push_i),
        .pc_i        (pc_i),
        .empty_i     (empty),
        .top_start_i (top_start),
        .top_end_i   (top_end),
        .top_cnt_i   (top_cnt),
        .op_o        (op),
        .next_pc_o   (next_pc_o),
        .loop_back_o (loop_back_o)
    );

    loop_stack #(.STACK_DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stack (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op),
        .new_start_i (pc_i + ADDR_W'(1)),
        .new_end_i   (push_end_i),
        .new_cnt_i   (push_cnt_i),
        .top_start_o (top_start),
        .top_end_o   (top_end),
        .top_cnt_o   (top_cnt),
        .empty_o     (empty),
        .depth_o     (depth_o),
        .overflow_o  (overflow_o)
    );

    assert_loopback_keeps_depth_R4: assert property (@(posedge clk) disable iff (rst)
        loop_back_o |=> $stable(depth_o));

    assert_exit_pops_R5: assert property (@(posedge clk) disable iff (rst)
        (fetch_i && !push_i && !loop_back_o && depth_o != '0 && pc_i == top_end)
        |=> (depth_o == $past(depth_o) - SP_W'(1)));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!fetch_i && !push_i) |=> ($stable(depth_o) && $stable(overflow_o)));

    assert_idle_no_redirect_R10: assert property (@(posedge clk) disable iff (rst)
        !fetch_i |-> !loop_back_o);

endmodule

// File: tb/sim_loop_sequencer.sv
module sim_loop_sequencer;

    localparam int AW = 16;
    localparam int CW = 16;
    localparam int SPW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          fetch_i;
    logic [AW-1:0] pc_i;
    logic          push_i;
    logic [CW-1:0] push_cnt_i;
    logic [AW-1:0] push_end_i;
    logic [AW-1:0] next_pc_o;
    logic          loop_back_o;
    logic [SPW-1:0] depth_o;
    logic          overflow_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    loop_sequencer #(.STACK_DEPTH(6), .ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .fetch_i(fetch_i), .pc_i(pc_i), .push_i(push_i),
        .push_cnt_i(push_cnt_i), .push_end_i(push_end_i), .next_pc_o(next_pc_o),
        .loop_back_o(loop_back_o), .depth_o(depth_o), .overflow_o(overflow_o)
    );

    // program description for run_prog: loop-start addresses, end addresses, counts
    int do_at  [4];
    int do_end [4];
    int do_cnt [4];
    int n_do;
    int seen_nx;
    int seen_lb;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, sample outputs before the posedge
    task automatic step(input int pc, input bit f, input bit p, input int cnt, input int e);
        @(negedge clk);
        pc_i       = AW'(pc);
        fetch_i    = f;
        push_i     = p;
        push_cnt_i = CW'(cnt);
        push_end_i = AW'(e);
        #1;
        seen_nx = int'(next_pc_o);
        seen_lb = int'(loop_back_o);
        @(posedge clk);
    endtask

    task automatic idle_settle();
        @(negedge clk);
        fetch_i = 1'b0;
        push_i  = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fetch_i = 1'b0; push_i = 1'b0;
        pc_i = '0; push_cnt_i = '0; push_end_i = '0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_prog(input int first, input int exit_pc,
                            output int fetches, output int backs);
        int pc;
        pc = first; fetches = 0; backs = 0;
        while (pc != exit_pc && fetches < 200) begin
            bit hitdo; int c; int e;
            hitdo = 0; c = 0; e = 0;
            for (int k = 0; k < n_do; k++)
                if (do_at[k] == pc) begin hitdo = 1; c = do_cnt[k]; e = do_end[k]; end
            step(pc, 1'b1, hitdo, c, e);
            fetches++;
            backs += seen_lb;
            pc = seen_nx;
        end
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 depth", int'(depth_o), 0);
        check("R1 overflow", int'(overflow_o), 0);
        step(40, 1'b1, 1'b0, 0, 0);
        check("R1 next_pc", seen_nx, 41);
        check("R1 loop_back", seen_lb, 0);
    endtask

    task automatic t_single();
        int f, b;
        do_reset();
        n_do = 1; do_at[0] = 10; do_end[0] = 12; do_cnt[0] = 3;
        step(10, 1'b1, 1'b1, 3, 12);
        idle_settle();
        check("R2 depth after push", int'(depth_o), 1);
        step(11, 1'b1, 1'b0, 0, 0);
        check("R11 body next_pc", seen_nx, 12);
        step(12, 1'b1, 1'b0, 0, 0);
        check("R4 redirect same cycle", seen_nx, 11);
        check("R4 loop_back", seen_lb, 1);
        idle_settle();
        check("R4 depth kept", int'(depth_o), 1);
        n_do = 0;
        run_prog(11, 13, f, b);
        check("R4 remaining fetches", f, 4);
        check("R5 remaining loop_backs", b, 1);
        idle_settle();
        check("R5 popped", int'(depth_o), 0);
    endtask

    task automatic t_small_counts();
        int f, b;
        for (int c = 0; c < 2; c++) begin
            do_reset();
            n_do = 1; do_at[0] = 300; do_end[0] = 302; do_cnt[0] = c;
            run_prog(300, 303, f, b);
            check("R6 fetches count0/1", f, 3);
            check("R6 no loop_back", b, 0);
            idle_settle();
            check("R6 depth back to 0", int'(depth_o), 0);
        end
    endtask

    task automatic t_nested();
        int f, b;
        do_reset();
        n_do = 2;
        do_at[0] = 20; do_end[0] = 25; do_cnt[0] = 2;
        do_at[1] = 21; do_end[1] = 23; do_cnt[1] = 3;
        run_prog(20, 26, f, b);
        check("R7 nested fetches", f, 19);
        check("R7 nested loop_backs", b, 5);
        idle_settle();
        check("R7 nested depth", int'(depth_o), 0);
    endtask

    task automatic t_shared_end();
        int f, b;
        do_reset();
        n_do = 2;
        do_at[0] = 30; do_end[0] = 33; do_cnt[0] = 2;
        do_at[1] = 31; do_end[1] = 33; do_cnt[1] = 2;
        run_prog(30, 34, f, b);
        check("R8 shared fetches", f, 6);
        check("R8 shared loop_backs", b, 1);
        idle_settle();
        check("R8 outer still active", int'(depth_o), 1);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 7; i++) step(100 + i, 1'b1, 1'b1, 1, 200 + i);
        idle_settle();
        check("R3 depth capped", int'(depth_o), 6);
        check("R3 overflow set", int'(overflow_o), 1);
        step(206, 1'b1, 1'b0, 0, 0);
        idle_settle();
        check("R3 dropped entry not compared", int'(depth_o), 6);
        step(205, 1'b1, 1'b0, 0, 0);
        check("R3 top entry next_pc", seen_nx, 206);
        idle_settle();
        check("R3 top entry pops", int'(depth_o), 5);
        check("R3 overflow sticky", int'(overflow_o), 1);
        do_reset();
        #1;
        check("R3 overflow cleared by reset", int'(overflow_o), 0);
    endtask

    task automatic t_push_at_end();
        do_reset();
        step(58, 1'b1, 1'b1, 3, 60);
        step(60, 1'b1, 1'b1, 2, 70);
        check("R9 no loop_back on push", seen_lb, 0);
        check("R9 next_pc on push", seen_nx, 61);
        idle_settle();
        check("R9 depth", int'(depth_o), 2);
    endtask

    task automatic t_idle();
        do_reset();
        step(80, 1'b1, 1'b1, 2, 81);
        step(81, 1'b0, 1'b0, 0, 0);
        check("R10 no redirect when idle", seen_lb, 0);
        idle_settle();
        check("R10 depth held", int'(depth_o), 1);
        step(81, 1'b1, 1'b0, 0, 0);
        check("R10 count not consumed", seen_lb, 1);
        check("R4 single-instruction loop", seen_nx, 81);
        step(81, 1'b1, 1'b0, 0, 0);
        check("R5 exit next_pc", seen_nx, 82);
        idle_settle();
        check("R5 depth after exit", int'(depth_o), 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; fetch_i = 1'b0; push_i = 1'b0;
        pc_i = '0; push_cnt_i = '0; push_end_i = '0; n_do = 0;
        t_reset();
        t_single();
        t_small_counts();
        t_nested();
        t_shared_end();
        t_overflow();
        t_push_at_end();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule